// File: doc/BRIEF.md
# Transmit DMA Channel Status and Error Unit

This block sits beside the transmit DMA engines and keeps the control and supervision state for a set of transmit channels (eight by default). For each channel it holds a small configuration word (a run mode and a request-enable bit), a one-deep request buffer that holds an accepted activate command until its buffer-done event, and a credit counter. The counter falls for each dword the channel issues toward the transmit FIFO and rises for each credit the FIFO returns.

Software sees everything through one register port. That port holds a configuration word and a read-only credit readout for each channel, one shared status word and one shared error word. The status word reports which channels have returned all their credits and which have no request pending. A channel counts as idle when both of those are true. The error word latches faults as sticky bits, and software clears them by writing ones:
- an internal address fault;
- a short host transfer;
- an activate command that arrives while the channel's request buffer is still occupied;
- a FIFO-full report that arrives while the channel's credit counter is not zero.

The error interrupt is raised while any error bit is set.

Top module: `txdma_chan_monitor`

## Requirements
- R1: After reset:
  - every configuration word reads 0;
  - every credit readout equals CREDIT_MAX (16);
  - the status word reads 0xFFFF0000;
  - the error word reads 0;
  - err_irq is 0.
- R2: Register map and configuration word:
  - Channel c's configuration word is at byte address 0x20*c, and its credit readout is at 0x20*c+4 (value in the low bits, read-only).
  - A configuration write keeps only bits 31:30 (mode) and bit 3 (request enable). All other bits read back as 0.
- R3: An activate command on channel c is accepted only when its mode is 2'b10 (run) and its request-enable bit is 1. An accepted command marks the request pending. In every other mode, or with request enable 0, the command leaves the request state unchanged.
- R4: A buffer-done event clears a pending request in mode 2'b10 (run) or mode 2'b01 (stop after frame). In any other mode it is ignored and the request stays pending.
- R5: Credit counter:
  - It decrements by one per dword-issue pulse and increments by one per credit-return pulse.
  - It saturates at 0 and at CREDIT_MAX.
  - When both pulses arrive in the same cycle, it is unchanged.
- R6: Status word (address 0x100):
  - Bit 24+c is 1 exactly when channel c's credit equals CREDIT_MAX.
  - Bit 16+c is 1 exactly when channel c has no pending request.
  - All other bits read 0.
- R7: An activate command on channel c while its request is pending sets error bit 9+c and leaves the pending request in place.
- R8: A FIFO-full report on channel c while its credit is non-zero sets error bit c. With credit zero it sets nothing.
- R9: The address-fault input sets error bit 31, and the short-transfer input sets error bit 30.
- R10: Error word (address 0x108) clearing:
  - Writing a 1 to an error bit clears it. Writing a 0 leaves it unchanged.
  - If an event sets a bit in the same cycle that software clears it, the bit stays set.
- R11: err_irq is 1 exactly when at least one error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| act_cmd | input | NCH | Per-channel activate command pulse |
| buf_done | input | NCH | Per-channel buffer-done pulse |
| dword_issue | input | NCH | Per-channel dword-issued pulse |
| credit_ret | input | NCH | Per-channel credit-return pulse |
| fifo_full | input | NCH | Per-channel transmit FIFO full report |
| addr_err | input | 1 | Internal memory address fault |
| short_xfer | input | 1 | Host delivered fewer dwords than expected |
| err_irq | output | 1 | Error interrupt |

## Verification
Activate commands are applied under each mode and request-enable combination. Accepted commands can then be told apart from ignored ones through the no-pending status bit, and a second command on an occupied buffer is told apart from a first command by the collision error bit. The credit counter is driven by single issue pulses, issue and return pulses in the same cycle, and runs long enough to reach both saturation points. FIFO-full reports are then applied at zero and at non-zero credit, which separates a real mismatch from a legitimate full. The clear path is tried with zero writes, partial masks and a clear that lands in the same cycle as a set, which shows whether set priority and per-bit masking hold.

// File: rtl/txdma_chan_monitor.sv
`timescale 1ns/1ps
module txdma_chan_monitor #(
  parameter int NCH        = 8,
  parameter int CREDIT_MAX = 16,
  localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [8:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NCH-1:0]  act_cmd,
  input  logic [NCH-1:0]  buf_done,
  input  logic [NCH-1:0]  dword_issue,
  input  logic [NCH-1:0]  credit_ret,
  input  logic [NCH-1:0]  fifo_full,
  input  logic            addr_err,
  input  logic            short_xfer,
  output logic            err_irq
);
  localparam logic [1:0] MODE_RUN  = 2'b10;
  localparam logic [1:0] MODE_STOP = 2'b01;

  logic [NCH-1:0][1:0]    mode_q;
  logic [NCH-1:0]         req_en_q;
  logic [NCH-1:0]         pend_q;
  logic [NCH-1:0][CW-1:0] cred_q;
  logic [31:0]            err_q, err_set, err_mask, stat;
  logic [NCH-1:0]         cfg_we;
  logic                   err_we;

  assign err_we  = reg_we && reg_addr == 9'h108;
  assign err_irq = |err_q;

  always_comb begin
    err_mask = 32'h0;
    err_set  = 32'h0;
    stat     = 32'h0;
    err_mask[31] = 1'b1;
    err_mask[30] = 1'b1;
    err_set[31]  = addr_err;
    err_set[30]  = short_xfer;
    for (int c = 0; c < NCH; c++) begin
      cfg_we[c]      = reg_we && reg_addr == 9'(32 * c);
      err_mask[c]    = 1'b1;
      err_mask[9+c]  = 1'b1;
      err_set[c]     = fifo_full[c] && cred_q[c] != '0;
      err_set[9+c]   = act_cmd[c] && pend_q[c];
      stat[24+c]     = cred_q[c] == CW'(CREDIT_MAX);
      stat[16+c]     = !pend_q[c];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic accept, finish;
    assign accept = act_cmd[c] && !pend_q[c] && mode_q[c] == MODE_RUN && req_en_q[c];
    assign finish = buf_done[c] && pend_q[c] &&
                    (mode_q[c] == MODE_RUN || mode_q[c] == MODE_STOP);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[c]   <= 2'b00;
        req_en_q[c] <= 1'b0;
        pend_q[c]   <= 1'b0;
        cred_q[c]   <= CW'(CREDIT_MAX);
      end else begin
        if (cfg_we[c]) begin
          mode_q[c]   <= reg_wdata[31:30];
          req_en_q[c] <= reg_wdata[3];
        end
        if (accept)      pend_q[c] <= 1'b1;
        else if (finish) pend_q[c] <= 1'b0;
        if (dword_issue[c] && !credit_ret[c] && cred_q[c] != '0)
          cred_q[c] <= cred_q[c] - 1'b1;
        else if (credit_ret[c] && !dword_issue[c] && cred_q[c] != CW'(CREDIT_MAX))
          cred_q[c] <= cred_q[c] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 32'h0;
    else        err_q <= (err_q & ~(err_we ? (reg_wdata & err_mask) : 32'h0)) | err_set;
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (!reg_addr[8]) begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr[7:5] == 3'(c)) begin
          if (reg_addr[4:0] == 5'h00)
            reg_rdata = {mode_q[c], 26'h0, req_en_q[c], 3'b000};
          else if (reg_addr[4:0] == 5'h04)
            reg_rdata = 32'(cred_q[c]);
        end
      end
    end else if (reg_addr[7:0] == 8'h00) begin
      reg_rdata = stat;
    end else if (reg_addr[7:0] == 8'h08) begin
      reg_rdata = err_q;
    end
  end
endmodule

module txdma_chan_monitor_chk #(
  parameter int NCH        = 8,
  parameter int CREDIT_MAX = 16,
  parameter int CW         = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         act_cmd,
  input logic [NCH-1:0]         fifo_full,
  input logic                   addr_err,
  input logic                   short_xfer,
  input logic                   err_irq,
  input logic [31:0]            err_q,
  input logic [NCH-1:0]         pend_q,
  input logic [NCH-1:0][1:0]    mode_q,
  input logic [NCH-1:0][CW-1:0] cred_q
);
  a_r9_addr_fault: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> err_q[31]);
  a_r9_short_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    short_xfer |=> err_q[30]);
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(addr_err || short_xfer || (|act_cmd) || (|fifo_full)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cred_q[c] <= CW'(CREDIT_MAX));
    a_r7_collision: assert property (@(posedge clk) disable iff (!rst_n)
      act_cmd[c] && pend_q[c] |=> err_q[9+c] && pend_q[c]);
    a_r8_full_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full[c] && cred_q[c] != '0 |=> err_q[c]);
    a_r4_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[c] && mode_q[c] == 2'b00 |=> pend_q[c]);
  end
endmodule

bind txdma_chan_monitor txdma_chan_monitor_chk #(
  .NCH(NCH), .CREDIT_MAX(CREDIT_MAX), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .act_cmd(act_cmd), .fifo_full(fifo_full),
  .addr_err(addr_err), .short_xfer(short_xfer), .err_irq(err_irq),
  .err_q(err_q), .pend_q(pend_q), .mode_q(mode_q), .cred_q(cred_q)
);

// File: tb/txdma_chan_monitor_test.sv
`timescale 1ns/1ps
module txdma_chan_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  act_cmd = '0, buf_done = '0, dword_issue = '0, credit_ret = '0, fifo_full = '0;
  logic        addr_err = 1'b0, short_xfer = 1'b0;
  logic        err_irq;
  int checks = 0, fails = 0;

  txdma_chan_monitor uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_cmd(act_cmd),
    .buf_done(buf_done), .dword_issue(dword_issue), .credit_ret(credit_ret),
    .fifo_full(fifo_full), .addr_err(addr_err), .short_xfer(short_xfer),
    .err_irq(err_irq)
  );

  always #10 clk = ~clk;

  localparam logic [8:0] STAT = 9'h100, ERR = 9'h108;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [8:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 cfg", 9'h060, 32'h0);
    rd_chk("R1 credit", 9'h0E4, 32'd16);
    rd_chk("R1 status", STAT, 32'hFFFF0000);
    rd_chk("R1 error", ERR, 32'h0);
    chk("R1 irq", 32'(err_irq), 32'h0);
  endtask

  task automatic t_cfg;
    wr(9'h060, 32'hFFFFFFFF);
    rd_chk("R2 cfg mask", 9'h060, 32'hC0000008);
    rd_chk("R2 neighbour", 9'h040, 32'h0);
    rd_chk("R2 credit ro", 9'h0A4, 32'd16);
    wr(9'h060, 32'h0);
  endtask

  task automatic t_accept;
    wr(9'h020, 32'h80000000);
    act_cmd = 8'h02; @(negedge clk); act_cmd = '0;
    rd_chk("R3 no req enable", STAT, 32'hFFFF0000);
    wr(9'h040, 32'h40000008);
    act_cmd = 8'h04; @(negedge clk); act_cmd = '0;
    rd_chk("R3 stop mode", STAT, 32'hFFFF0000);
    wr(9'h020, 32'h80000008);
    act_cmd = 8'h02; @(negedge clk); act_cmd = '0;
    rd_chk("R3 accepted", STAT, 32'hFFFD0000);
    rd_chk("R3 no error", ERR, 32'h0);
  endtask

  task automatic t_done;
    wr(9'h020, 32'h0);
    buf_done = 8'h02; @(negedge clk); buf_done = '0;
    rd_chk("R4 off ignores done", STAT, 32'hFFFD0000);
    wr(9'h020, 32'h40000000);
    buf_done = 8'h02; @(negedge clk); buf_done = '0;
    rd_chk("R4 stop-after-frame done", STAT, 32'hFFFF0000);
  endtask

  task automatic t_credit;
    for (int i = 0; i < 3; i++) begin
      dword_issue = 8'h10; @(negedge clk);
    end
    dword_issue = '0;
    rd_chk("R5 decrement", 9'h084, 32'd13);
    rd_chk("R6 not empty", STAT, 32'hEFFF0000);
    dword_issue = 8'h10; credit_ret = 8'h10; @(negedge clk);
    dword_issue = '0; credit_ret = '0;
    rd_chk("R5 simultaneous", 9'h084, 32'd13);
    for (int i = 0; i < 5; i++) begin
      credit_ret = 8'h10; @(negedge clk);
    end
    credit_ret = '0;
    rd_chk("R5 saturate max", 9'h084, 32'd16);
    rd_chk("R6 empty again", STAT, 32'hFFFF0000);
    for (int i = 0; i < 20; i++) begin
      dword_issue = 8'h10; @(negedge clk);
    end
    dword_issue = '0;
    rd_chk("R5 saturate zero", 9'h084, 32'd0);
  endtask

  task automatic t_full;
    fifo_full = 8'h10; @(negedge clk); fifo_full = '0;
    rd_chk("R8 zero credit no error", ERR, 32'h0);
    credit_ret = 8'h10; @(negedge clk); credit_ret = '0;
    fifo_full = 8'h10; @(negedge clk); fifo_full = '0;
    rd_chk("R8 mismatch", ERR, 32'h00000010);
    chk("R11 irq set", 32'(err_irq), 32'h1);
    wr(ERR, 32'h00000010);
    rd_chk("R10 clear", ERR, 32'h0);
    chk("R11 irq clear", 32'(err_irq), 32'h0);
  endtask

  task automatic t_collide;
    wr(9'h0C0, 32'h80000008);
    act_cmd = 8'h40; @(negedge clk);
    rd_chk("R7 first accepted", STAT, 32'hEFBF0000);
    rd_chk("R7 no error yet", ERR, 32'h0);
    @(negedge clk); act_cmd = '0;
    rd_chk("R7 collision", ERR, 32'h00008000);
    rd_chk("R7 still pending", STAT, 32'hEFBF0000);
  endtask

  task automatic t_shared;
    addr_err = 1'b1; @(negedge clk); addr_err = 1'b0;
    rd_chk("R9 address fault", ERR, 32'h80008000);
    short_xfer = 1'b1; @(negedge clk); short_xfer = 1'b0;
    rd_chk("R9 short transfer", ERR, 32'hC0008000);
  endtask

  task automatic t_w1c;
    wr(ERR, 32'h0);
    rd_chk("R10 zero write", ERR, 32'hC0008000);
    wr(ERR, 32'h40000000);
    rd_chk("R10 partial clear", ERR, 32'h80008000);
    addr_err = 1'b1;
    wr(ERR, 32'h80000000);
    addr_err = 1'b0;
    rd_chk("R10 set wins", ERR, 32'h80008000);
    wr(ERR, 32'hFFFFFFFF);
    rd_chk("R10 clear all", ERR, 32'h0);
    chk("R11 irq low", 32'(err_irq), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_accept();
    t_done();
    t_credit();
    t_full();
    t_collide();
    t_shared();
    t_w1c();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule